// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block collects interrupt requests for a small multi-core system and decides, for each core, which request should be forwarded to that core's CPU interface. Shared lines are wired to all cores. Per-core private lines and software requests are banked, so every core has its own copy of their enable and pending state. Each interrupt carries a trigger mode, an 8-bit priority and, for shared lines, a byte-wide mask that selects which cores may receive it.

Software programs the block through a plain 32-bit word-addressed register bus. A `bus_cpu` input tells the block which core is making the access, and that choice selects the banked copy. For each core the block continuously presents the best forwardable interrupt: its ID, its priority and a valid flag. The CPU interface reports an acknowledge back through `ack_valid`/`ack_id`.

Register map (word addresses): control 0x00, type 0x01, software request 0x02, set-enable 0x08+k, clear-enable 0x0C+k, pending (read-only) 0x10+k, trigger 0x20+k, priority 0x40+k, target 0x80+k.

Top module: `irq_distributor`

## Requirements
- R1: After reset, control bit 0, every enable bit and every pending bit are 0, and no core has a valid forwarded interrupt.
- R2: Word k at 0x08+k sets enable bits and word k at 0x0C+k clears them, for IDs 32k..32k+31 (bit b is ID 32k+b). Only one bits act and zero bits have no effect. Reading either address returns the current enable bits.
- R3: In trigger word k at 0x20+k, bit 2j+1 selects rising-edge (1) or level-high (0) for ID 16k+j. IDs 0-15 always read as 2'b10 and ignore writes.
- R4: An edge interrupt becomes pending on a 0-to-1 input transition sampled at a clock edge, stays pending after the input falls, and clears on an acknowledge of its ID. A level interrupt is pending in the cycle after its input is sampled high, follows the input, and is not cleared by an acknowledge.
- R5: Priority word k at 0x40+k and target word k at 0x80+k hold IDs 4k..4k+3, one byte each with ID 4k in bits 7:0. Target bit n routes a shared ID to core n, and only NUM_CPU bits are stored. Targets of IDs 0-31 ignore writes and read as the requesting core's own bit.
- R6: While control bit 0 at 0x00 is 0, no interrupt is forwarded to any core, and pending state is kept.
- R7: A write to 0x02 makes the ID in bits 3:0 pending on every core n whose bit 16+n is set.
- R8: Enable and pending state of IDs 0-31 is banked per core and selected by `bus_cpu`, and an acknowledge from core n clears only core n's copy.
- R9: Each core is offered the pending, enabled interrupt routed to it that has the numerically lowest priority value. A tie goes to the lowest ID. `fwd_id` and `fwd_prio` report the chosen interrupt.
- R10: The type word at 0x01 reads NUM_IRQ/32-1 in bits 4:0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cpu | input | CPU_W | Core making the register access |
| bus_addr | input | 8 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| spi_in | input | NUM_IRQ-32 | Shared interrupt lines, IDs 32 and up |
| ppi_in | input | NUM_CPU*16 | Private lines, IDs 16-31, 16 per core |
| ack_valid | input | NUM_CPU | Acknowledge strobe per core |
| ack_id | input | NUM_CPU*ID_W | Acknowledged ID per core |
| fwd_valid | output | NUM_CPU | Forwarded interrupt valid per core |
| fwd_id | output | NUM_CPU*ID_W | Forwarded ID per core |
| fwd_prio | output | NUM_CPU*8 | Priority of the forwarded ID per core |

## Verification
The bench builds the block with 64 IDs and two cores. Two cores are enough to show banking: a software request aimed at one core, an acknowledge that clears only one copy, and a target mask that reaches one core but not the other. With 64 IDs there is a second enable word and a second trigger word for shared lines beside the fixed ones, so set and clear words, read-only trigger pairs, target masking to two bits, and level-versus-edge pending can all be checked on real shared IDs.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
   localparam int A_CTRL  = 'h00;
   localparam int A_TYPE  = 'h01;
   localparam int A_SWI   = 'h02;
   localparam int A_ENSET = 'h08;
   localparam int A_ENCLR = 'h0C;
   localparam int A_PEND  = 'h10;
   localparam int A_CFG   = 'h20;
   localparam int A_PRIO  = 'h40;
   localparam int A_TGT   = 'h80;
   localparam int PRIO_W  = 8;
   localparam int BANKED  = 32;
   localparam int SWI_CNT = 16;
endpackage

// File: rtl/irq_dist_pend.sv
module irq_dist_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_mode,
   input  logic line_in,
   input  logic sw_set,
   input  logic ack_clr,
   output logic pend
);
   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         line_q <= line_in;
         if (!edge_mode)
            pend <= line_in;
         else if ((line_in && !line_q) || sw_set)
            pend <= 1'b1;
         else if (ack_clr)
            pend <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_dist_sel.sv
module irq_dist_sel
   import irq_dist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   localparam int ID_W = $clog2(NUM_IRQ)
) (
   input  logic [NUM_IRQ-1:0]             cand,
   input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
   output logic                           valid,
   output logic [ID_W-1:0]                id,
   output logic [PRIO_W-1:0]              prio_o
);
   always_comb begin
      valid  = 1'b0;
      id     = '0;
      prio_o = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (cand[i] && (!valid || prio[i] < prio_o)) begin
            valid  = 1'b1;
            id     = ID_W'(i);
            prio_o = prio[i];
         end
      end
   end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irq_dist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 2,
   localparam int ID_W  = $clog2(NUM_IRQ),
   localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int NSH   = NUM_IRQ - BANKED
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CPU_W-1:0]          bus_cpu,
   input  logic [7:0]                bus_addr,
   input  logic                      bus_we,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   input  logic [NSH-1:0]            spi_in,
   input  logic [NUM_CPU*16-1:0]     ppi_in,
   input  logic [NUM_CPU-1:0]        ack_valid,
   input  logic [NUM_CPU*ID_W-1:0]   ack_id,
   output logic [NUM_CPU-1:0]        fwd_valid,
   output logic [NUM_CPU*ID_W-1:0]   fwd_id,
   output logic [NUM_CPU*PRIO_W-1:0] fwd_prio
);
   localparam int NWORD = NUM_IRQ / 32;

   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 64 || NUM_IRQ > 128) begin : g_bad_irq
      $error("NUM_IRQ must be 64 or 96 or 128");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 1..8");
   end

   logic                             ctrl_en;
   logic [NUM_CPU-1:0][31:0]         en_bank;
   logic [NWORD-2:0][31:0]           en_sh;
   logic [NUM_IRQ-1:16]              cfg_edge;
   logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio_q;
   logic [NUM_IRQ-1:32][NUM_CPU-1:0] tgt_q;
   logic [NUM_CPU-1:0][31:0]         pend_bank;
   logic [NSH-1:0]                   pend_sh;
   logic [NUM_CPU-1:0][31:0]         ack_bank;
   logic [NSH-1:0]                   ack_sh;
   logic [NUM_CPU-1:0][15:0]         swi_set;
   logic [NUM_CPU*NUM_IRQ-1:0]       en_flat, pend_flat, elig_flat;
   int                               a;

   assign a = int'(bus_addr);

   // configuration state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         en_bank  <= '0;
         en_sh    <= '0;
         cfg_edge <= '0;
         prio_q   <= '0;
         tgt_q    <= '0;
      end else if (bus_we) begin
         if (a == A_CTRL) ctrl_en <= bus_wdata[0];
         if (a == A_ENSET) en_bank[bus_cpu] <= en_bank[bus_cpu] | bus_wdata;
         if (a == A_ENCLR) en_bank[bus_cpu] <= en_bank[bus_cpu] & ~bus_wdata;
         for (int w = 1; w < NWORD; w++) begin
            if (a == A_ENSET + w) en_sh[w-1] <= en_sh[w-1] | bus_wdata;
            if (a == A_ENCLR + w) en_sh[w-1] <= en_sh[w-1] & ~bus_wdata;
         end
         for (int i = SWI_CNT; i < NUM_IRQ; i++)
            if (a == A_CFG + i/16) cfg_edge[i] <= bus_wdata[(i%16)*2+1];
         for (int i = 0; i < NUM_IRQ; i++)
            if (a == A_PRIO + i/4) prio_q[i] <= bus_wdata[(i%4)*8 +: PRIO_W];
         for (int i = BANKED; i < NUM_IRQ; i++)
            if (a == A_TGT + i/4) tgt_q[i] <= bus_wdata[(i%4)*8 +: NUM_CPU];
      end
   end

   // software requests and acknowledges
   always_comb begin
      ack_sh = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         for (int k = 0; k < 16; k++)
            swi_set[c][k] = bus_we && (a == A_SWI) && bus_wdata[16+c] &&
                            (bus_wdata[3:0] == 4'(k));
         for (int i = 0; i < BANKED; i++)
            ack_bank[c][i] = ack_valid[c] && (ack_id[c*ID_W +: ID_W] == ID_W'(i));
         for (int j = 0; j < NSH; j++)
            if (ack_valid[c] && (ack_id[c*ID_W +: ID_W] == ID_W'(j + BANKED)))
               ack_sh[j] = 1'b1;
      end
   end

   // pending cells: banked software and private lines, then shared lines
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      for (genvar i = 0; i < SWI_CNT; i++) begin : g_swi
         irq_dist_pend u_pend (
            .clk(clk), .rst_n(rst_n), .edge_mode(1'b1), .line_in(1'b0),
            .sw_set(swi_set[c][i]), .ack_clr(ack_bank[c][i]), .pend(pend_bank[c][i]));
      end
      for (genvar i = SWI_CNT; i < BANKED; i++) begin : g_ppi
         irq_dist_pend u_pend (
            .clk(clk), .rst_n(rst_n), .edge_mode(cfg_edge[i]),
            .line_in(ppi_in[c*16 + i - SWI_CNT]), .sw_set(1'b0),
            .ack_clr(ack_bank[c][i]), .pend(pend_bank[c][i]));
      end
      assign en_flat[c*NUM_IRQ +: NUM_IRQ]   = {en_sh, en_bank[c]};
      assign pend_flat[c*NUM_IRQ +: NUM_IRQ] = {pend_sh, pend_bank[c]};
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_elig
         if (i < BANKED) begin : g_own
            assign elig_flat[c*NUM_IRQ+i] = en_flat[c*NUM_IRQ+i] && pend_flat[c*NUM_IRQ+i];
         end else begin : g_routed
            assign elig_flat[c*NUM_IRQ+i] = en_flat[c*NUM_IRQ+i] &&
                                            pend_flat[c*NUM_IRQ+i] && tgt_q[i][c];
         end
      end
      irq_dist_sel #(.NUM_IRQ(NUM_IRQ)) u_sel (
         .cand   (ctrl_en ? elig_flat[c*NUM_IRQ +: NUM_IRQ] : '0),
         .prio   (prio_q),
         .valid  (fwd_valid[c]),
         .id     (fwd_id[c*ID_W +: ID_W]),
         .prio_o (fwd_prio[c*PRIO_W +: PRIO_W]));
   end

   for (genvar j = 0; j < NSH; j++) begin : g_spi
      irq_dist_pend u_pend (
         .clk(clk), .rst_n(rst_n), .edge_mode(cfg_edge[j+BANKED]),
         .line_in(spi_in[j]), .sw_set(1'b0), .ack_clr(ack_sh[j]), .pend(pend_sh[j]));
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (a == A_CTRL) bus_rdata[0] = ctrl_en;
      if (a == A_TYPE) bus_rdata[4:0] = 5'(NWORD - 1);
      for (int w = 0; w < NWORD; w++) begin
         if (a == A_ENSET + w || a == A_ENCLR + w)
            bus_rdata = en_flat[int'(bus_cpu)*NUM_IRQ + w*32 +: 32];
         if (a == A_PEND + w)
            bus_rdata = pend_flat[int'(bus_cpu)*NUM_IRQ + w*32 +: 32];
      end
      for (int i = 0; i < SWI_CNT; i++)
         if (a == A_CFG) bus_rdata[i*2+1] = 1'b1;
      for (int i = SWI_CNT; i < NUM_IRQ; i++)
         if (a == A_CFG + i/16) bus_rdata[(i%16)*2+1] = cfg_edge[i];
      for (int i = 0; i < NUM_IRQ; i++)
         if (a == A_PRIO + i/4) bus_rdata[(i%4)*8 +: PRIO_W] = prio_q[i];
      for (int i = 0; i < BANKED; i++)
         if (a == A_TGT + i/4) bus_rdata[(i%4)*8 + int'(bus_cpu)] = 1'b1;
      for (int i = BANKED; i < NUM_IRQ; i++)
         if (a == A_TGT + i/4) bus_rdata[(i%4)*8 +: NUM_CPU] = tgt_q[i];
   end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
   import irq_dist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 2,
   localparam int ID_W  = $clog2(NUM_IRQ),
   localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [CPU_W-1:0]         bus_cpu,
   input logic [7:0]               bus_addr,
   input logic                     bus_we,
   input logic [31:0]              bus_wdata,
   input logic [31:0]              bus_rdata,
   input logic                     ctrl_en,
   input logic [NUM_CPU-1:0]       fwd_valid,
   input logic [NUM_CPU*ID_W-1:0]  fwd_id,
   input logic [NUM_CPU*NUM_IRQ-1:0] en_flat,
   input logic [NUM_CPU*NUM_IRQ-1:0] pend_flat
);
   // R6
   fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> fwd_valid == '0);

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
      // R9
      fwd_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_valid[c] |-> (en_flat[c*NUM_IRQ + int'(fwd_id[c*ID_W +: ID_W])] &&
                           pend_flat[c*NUM_IRQ + int'(fwd_id[c*ID_W +: ID_W])]));
   end

   // R7
   swi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 8'(A_SWI) && bus_wdata[16])
      |=> pend_flat[$past(bus_wdata[3:0])]);

   // R2
   enclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 8'(A_ENCLR) && bus_cpu == '0)
      |=> (en_flat[31:0] & $past(bus_wdata)) == 32'h0);

   // R3
   always_comb begin
      if (rst_n && bus_addr == 8'(A_CFG))
         sgi_cfg_chk: assert (bus_rdata == 32'hAAAA_AAAA);
   end
endmodule

bind irq_distributor irq_dist_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
   .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .ctrl_en(ctrl_en), .fwd_valid(fwd_valid), .fwd_id(fwd_id),
   .en_flat(en_flat), .pend_flat(pend_flat));

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
   localparam int NUM_IRQ = 64;
   localparam int NUM_CPU = 2;
   localparam int ID_W = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [0:0]  bus_cpu = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] spi_in = '0;
   logic [31:0] ppi_in = '0;
   logic [1:0]  ack_valid = '0;
   logic [11:0] ack_id = '0;
   logic [1:0]  fwd_valid;
   logic [11:0] fwd_id;
   logic [15:0] fwd_prio;
   int nchk = 0, nerr = 0;

   always #10 clk = ~clk;

   irq_distributor #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) i_irq_distributor (
      .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_in(spi_in), .ppi_in(ppi_in), .ack_valid(ack_valid), .ack_id(ack_id),
      .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio));

   typedef struct packed {
      logic [7:0]  wa;
      logic [31:0] wd;
      logic [7:0]  ra;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{8'h00, 32'h0000_0001, 8'h00, 32'h0000_0001, 4'd6},  // R6 control bit
      '{8'h48, 32'hA0B0_C0D0, 8'h48, 32'hA0B0_C0D0, 4'd5},  // R5 priority
      '{8'h40, 32'h0102_0304, 8'h40, 32'h0102_0304, 4'd5},  // R5 banked priority
      '{8'h88, 32'h0302_0101, 8'h88, 32'h0302_0101, 4'd5},  // R5 target
      '{8'h88, 32'h0000_00FF, 8'h88, 32'h0000_0003, 4'd5},  // R5 target masked
      '{8'h80, 32'hFFFF_FFFF, 8'h80, 32'h0101_0101, 4'd5},  // R5 banked target
      '{8'h20, 32'h0000_0000, 8'h20, 32'hAAAA_AAAA, 4'd3},  // R3 fixed pairs
      '{8'h22, 32'hFFFF_FFFF, 8'h22, 32'hAAAA_AAAA, 4'd3},  // R3 upper bits
      '{8'h22, 32'h0000_0008, 8'h22, 32'h0000_0008, 4'd3},  // R3 id33 edge
      '{8'h09, 32'h0000_0005, 8'h09, 32'h0000_0005, 4'd2},  // R2 set
      '{8'h0D, 32'h0000_0004, 8'h09, 32'h0000_0001, 4'd2},  // R2 clear
      '{8'h01, 32'hFFFF_FFFF, 8'h01, 32'h0000_0001, 4'd10}  // R10 type
   };

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int cpu, input int adr, input logic [31:0] d);
      @(negedge clk);
      bus_cpu = 1'(cpu); bus_addr = 8'(adr); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int cpu, input int adr, output logic [31:0] d);
      bus_cpu = 1'(cpu); bus_addr = 8'(adr);
      #1 d = bus_rdata;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic ack(input int cpu, input int id);
      @(negedge clk);
      ack_valid[cpu] = 1'b1;
      ack_id[cpu*ID_W +: ID_W] = 6'(id);
      @(negedge clk);
      ack_valid = '0;
   endtask

   logic [31:0] r;

   initial begin
      #(20*100000);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      rd(0, 'h09, r); chk(1, r, 0, "enable word after reset");
      rd(0, 'h10, r); chk(1, r, 0, "pending word after reset");
      rd(0, 'h00, r); chk(1, r, 0, "control after reset");
      chk(1, 32'(fwd_valid), 0, "no forward after reset");

      for (int v = 0; v < 12; v++) begin
         wr(0, int'(VEC[v].wa), VEC[v].wd);
         rd(0, int'(VEC[v].ra), r);
         chk(int'(VEC[v].req), r, VEC[v].exp, $sformatf("vector %0d", v));
      end

      // route id32/33 to core 0, prio id32=0x30 id33=0x20, enable both
      wr(0, 'h88, 32'h0000_0101);
      wr(0, 'h48, 32'h0000_2030);
      wr(0, 'h09, 32'h0000_0002);
      // R4 level line 32
      spi_in[0] = 1'b1; step();
      chk(9, 32'(fwd_valid), 32'h1, "R9 level id32 only core0 valid");
      chk(9, 32'(fwd_id[5:0]), 32, "R9 id core0");
      chk(9, 32'(fwd_prio[7:0]), 32'h30, "R9 prio core0");
      // R4 edge line 33 pulse, held after fall
      spi_in[1] = 1'b1; step(); spi_in[1] = 1'b0; step();
      chk(4, 32'(fwd_id[5:0]), 33, "R4 edge id33 held and preferred");
      ack(0, 33);
      chk(4, 32'(fwd_id[5:0]), 32, "R4 ack clears edge id33");
      ack(0, 32);
      chk(4, {31'b0, fwd_valid[0]}, 1, "R4 ack does not clear level id32");
      // R6 gate
      wr(0, 'h00, 0);
      chk(6, 32'(fwd_valid), 0, "R6 forwarding off");
      rd(0, 'h11, r); chk(6, r, 32'h1, "R6 pending kept while off");
      wr(0, 'h00, 1);
      // R9 tie -> lower id
      wr(0, 'h48, 32'h0000_3030);
      spi_in[1] = 1'b1; step(); spi_in[1] = 1'b0; step();
      chk(9, 32'(fwd_id[5:0]), 32, "R9 tie picks lower id");
      ack(0, 33);
      spi_in[0] = 1'b0; step();
      chk(4, 32'(fwd_valid), 0, "R4 level falls, nothing pending");

      // R7 / R8 software request to core 1
      wr(1, 'h08, 32'h0000_0020);
      wr(0, 'h41, 32'h0000_1000);
      wr(0, 'h02, (32'h2 << 16) | 32'd5);
      chk(7, {31'b0, fwd_valid[1]}, 1, "R7 core1 receives swi");
      chk(7, 32'(fwd_id[11:6]), 5, "R7 swi id");
      chk(7, 32'(fwd_prio[15:8]), 32'h10, "R7 swi prio");
      rd(0, 'h10, r); chk(8, r, 0, "R8 core0 copy untouched");
      rd(1, 'h10, r); chk(8, r, 32'h20, "R8 core1 pending");
      rd(0, 'h08, r); chk(8, r, 0, "R8 core0 enables banked");
      wr(0, 'h02, (32'h3 << 16) | 32'd5);
      rd(0, 'h10, r); chk(7, r, 32'h20, "R7 two-core list");
      ack(1, 5);
      rd(1, 'h10, r); chk(8, r, 0, "R8 core1 ack clears own copy");
      rd(0, 'h10, r); chk(8, r, 32'h20, "R8 core0 copy survives");

      // R2 zero bits no effect
      wr(0, 'h09, 0);
      rd(0, 'h09, r); chk(2, r, 32'h3, "R2 zero set word");
      wr(0, 'h0D, 0);
      rd(0, 'h0D, r); chk(2, r, 32'h3, "R2 zero clear word");

      // R9 private line of core 1, id16 priority 0 beats id5
      wr(1, 'h02, (32'h2 << 16) | 32'd5);
      wr(1, 'h08, 32'h0001_0000);
      ppi_in[16] = 1'b1; step();
      chk(9, 32'(fwd_id[11:6]), 16, "R9 private line wins on priority");
      rd(1, 'h10, r); chk(8, r, 32'h0001_0020, "R8 core1 private pending");
      rd(0, 'h10, r); chk(8, r, 32'h20, "R8 core0 sees no private line");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule